// File: doc/BRIEF.md
# Prioritised Event Interrupt Controller

This block collects single-cycle event pulses from eight numbered sources and folds them into one fast-interrupt request line for an embedded CPU. Each source has a pending bit. A readable event-number register tells the CPU which event to service. The CPU acknowledges through a clear strobe, but the strobe only acts on every fourth write. Each acknowledge retires only the lowest pending event.

The reported number follows a simple replacement rule rather than a full priority encode. It can therefore hold a number that is not the lowest pending one, for example when a higher-numbered event arrives while the register still shows an older, lower number. After an acknowledge, the register moves upward to the next pending event, if there is one. Coming out of reset, the timer event (number 2) is already pending and the request line is already raised.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the pending bitmap is 8'b0000_0100 (only event 2 pending), the reported number is 2 and the request line is high.
- R2: A pulse on event input bit k sets pending bit k on the next clock edge, whatever the other pending bits hold.
- R3: When an event arrives while no bit is pending, the request line rises on the next edge. At all times the request line is high exactly when at least one pending bit is set.
- R4: When events arrive, the lowest arriving number replaces the reported number if the reported number is 0 or larger than it. Otherwise the reported number is kept.
- R5: Writes on the clear strobe are counted. The first three writes of each group of four change nothing visible, and the fourth write performs an acknowledge and returns the count to zero.
- R6: An acknowledge clears only the lowest-numbered set pending bit. With nothing pending, it clears nothing.
- R7: After an acknowledge, the reported number becomes the number of the lowest bit still pending, which is the next one above the retired bit. If no bit remains pending, the reported number is left unchanged.
- R8: The request line falls on the edge where an acknowledge leaves no pending bit, unless an event arrives in that same cycle.
- R9: When an event and an acknowledge happen in the same cycle, the acknowledge is applied first. The new pending bit is then recorded, and the R4 rule is applied against the number left by the acknowledge.
- R10: With no event and no clear write in a cycle, the pending bitmap and the reported number hold their values. Observing the outputs never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one bit per source; bit k is event k |
| clr_wr_i | input | 1 | One pulse per write to the clear register |
| irq_o | output | 1 | Fast-interrupt request line |
| evt_num_o | output | 3 | Reported event number |
| pending_o | output | 8 | Pending bitmap; bit k is event k |

## Verification
Directed sequences cover several cases:
- Single events arriving in rising and in falling number order, which separates the replace-on-smaller rule from a true priority encode.
- Runs of one to three clear writes, which show that the counter keeps the acknowledge back until the fourth write.
- An acknowledge with nothing pending.
- An event landing in the same cycle as an acknowledge, which shows whether the acknowledge is applied before the event is recorded.

Random phases then mix sparse and dense event bursts with frequent clear writes. Every cycle is compared against a bench model, so any drift in the counter phase or in the upward search shows up.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int N_SRC      = 8,
  parameter int ACK_WRITES = 4,
  parameter int RESET_EVT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_wr_i,
  output logic             irq_o,
  output logic [$clog2(N_SRC)-1:0] evt_num_o,
  output logic [N_SRC-1:0] pending_o
);
  localparam int IDW = $clog2(N_SRC);
  localparam int CW  = (ACK_WRITES > 1) ? $clog2(ACK_WRITES) : 1;
  localparam logic [CW-1:0] LAST_WR = CW'(ACK_WRITES - 1);

  function automatic logic [IDW-1:0] low_idx(input logic [N_SRC-1:0] v);
    low_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) low_idx = IDW'(i);
  endfunction

  logic [N_SRC-1:0] pend_q, pend_ack, pend_d, low_bit;
  logic [IDW-1:0]   num_q, num_ack, num_d, evt_lo;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             irq_q, irq_d, ack, take;

  assign ack      = clr_wr_i && (cnt_q == LAST_WR);
  assign cnt_d    = !clr_wr_i ? cnt_q : (ack ? '0 : cnt_q + 1'b1);

  assign low_bit  = pend_q & (~pend_q + 1'b1);
  assign pend_ack = ack ? (pend_q & ~low_bit) : pend_q;
  assign num_ack  = (ack && |pend_ack) ? low_idx(pend_ack) : num_q;

  assign evt_lo   = low_idx(evt_i);
  assign take     = |evt_i && (num_ack == '0 || num_ack > evt_lo);
  assign num_d    = take ? evt_lo : num_ack;
  assign pend_d   = pend_ack | evt_i;

  always_comb begin
    irq_d = irq_q;
    if (ack && pend_ack == '0) irq_d = 1'b0;
    if (|evt_i && pend_ack == '0) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= N_SRC'(1) << RESET_EVT;
      num_q  <= IDW'(RESET_EVT);
      irq_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      num_q  <= num_d;
      irq_q  <= irq_d;
      cnt_q  <= cnt_d;
    end
  end

  assign irq_o     = irq_q;
  assign evt_num_o = num_q;
  assign pending_o = pend_q;

  AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pending_o != '0)); // R3

  AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pending_o & $past(evt_i)) == $past(evt_i))); // R2

  AST_EARLY_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && cnt_q != LAST_WR) |=> (pending_o == ($past(pending_o) | $past(evt_i)))); // R5

  AST_ACK_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pending_o != '0 && evt_i == '0) |=>
      ($countones(pending_o) + 1 == $countones($past(pending_o)))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr_i && evt_i == '0) |=> ($stable(evt_num_o) && $stable(pending_o))); // R10
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       clr_wr_i = 1'b0;
  logic       irq_o;
  logic [2:0] evt_num_o;
  logic [7:0] pending_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_pend;
  logic [2:0] m_num;
  logic       m_irq;
  int         m_cnt;

  always #5 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_wr_i(clr_wr_i),
    .irq_o(irq_o), .evt_num_o(evt_num_o), .pending_o(pending_o)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [7:0] ev, input logic clr);
    int lo;
    if (clr) begin
      m_cnt++;
      if (m_cnt == 4) begin
        m_cnt = 0;
        lo = lowest(m_pend);
        if (lo >= 0) begin
          m_pend[lo] = 1'b0;
          for (int j = lo + 1; j < 8; j++)
            if (m_pend[j]) begin m_num = 3'(j); break; end
        end
        if (m_pend == '0) m_irq = 1'b0;
      end
    end
    if (ev != '0) begin
      if (m_pend == '0) m_irq = 1'b1;
      lo = lowest(ev);
      if (m_num == 0 || int'(m_num) > lo) m_num = 3'(lo);
      m_pend |= ev;
    end
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic cyc(input logic [7:0] ev, input logic clr, input string tag);
    evt_i = ev; clr_wr_i = clr;
    model_step(ev, clr);
    @(negedge clk);
    evt_i = '0; clr_wr_i = 1'b0;
    chk({tag, " pending"}, pending_o, m_pend);
    chk({tag, " number"}, evt_num_o, m_num);
    chk({tag, " irq"}, irq_o, m_irq);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_pend = 8'b0000_0100; m_num = 3'd2; m_irq = 1'b1; m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pending", pending_o, 8'h04);
    chk("R1 reset number", evt_num_o, 2);
    chk("R1 reset irq", irq_o, 1);

    // R5: three writes do nothing, fourth retires event 2
    cyc(8'h00, 1'b1, "R5 write1");
    cyc(8'h00, 1'b1, "R5 write2");
    cyc(8'h00, 1'b1, "R5 write3");
    chk("R5 still pending", pending_o, 8'h04);
    cyc(8'h00, 1'b1, "R5/R6/R8 write4");
    chk("R8 irq released", irq_o, 0);
    chk("R7 number kept", evt_num_o, 2);

    // R4 rising then falling order
    cyc(8'h20, 1'b0, "R3/R4 evt5");
    chk("R4 stale lower kept", evt_num_o, 2);
    chk("R3 irq raised", irq_o, 1);
    cyc(8'h02, 1'b0, "R4 evt1");
    chk("R4 smaller replaces", evt_num_o, 1);
    cyc(8'h08, 1'b0, "R2 evt3");
    cyc(8'h01, 1'b0, "R4 evt0");
    cyc(8'h40, 1'b0, "R4 evt6 over zero");
    chk("R4 zero replaced", evt_num_o, 6);
    cyc(8'h00, 1'b0, "R10 idle");
    // ack chain: retire 0 -> report 1
    repeat (3) cyc(8'h00, 1'b1, "R5 pre");
    cyc(8'h00, 1'b1, "R6/R7 ack");
    chk("R7 next higher", evt_num_o, 1);
    chk("R6 lowest retired", pending_o, 8'h6A);
    // R9: event with ack in same cycle
    repeat (3) cyc(8'h00, 1'b1, "R5 pre");
    cyc(8'h01, 1'b1, "R9 ack+evt0");
    chk("R9 event after ack", pending_o, 8'h69);
    chk("R9 number", evt_num_o, 0);
    // drain everything, then extra ack with nothing pending
    repeat (32) cyc(8'h00, 1'b1, "R6/R7/R8 drain");
    chk("R8 drained irq", irq_o, 0);
    chk("R6 drained pend", pending_o, 0);
    repeat (4) cyc(8'h00, 1'b1, "R6 empty ack");
    // R9 with empty result plus event keeps irq
    cyc(8'h10, 1'b0, "R3 evt4");
    repeat (3) cyc(8'h00, 1'b1, "R5 pre");
    cyc(8'h80, 1'b1, "R9/R8 ack+evt7");
    chk("R9 irq stays", irq_o, 1);

    // random: sparse then dense
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev;
      ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      if (n >= 1500) ev = 8'($urandom) & 8'($urandom);
      cyc(ev, 1'($urandom % 2), "R2/R4/R5/R6/R7/R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule